// File: doc/BRIEF.md
# APB Range Splitter with Unmapped-Address Error

This block sits between one upstream APB requester and a set of downstream APB completers. Each child owns one window of the address space, given by a base and a size in a parameter table. In the setup phase of a transfer the block decodes the address. It raises the select of the child whose window holds the address and broadcasts the address, direction, enable, write data and byte strobes to all children. The decoded target is then frozen for the rest of the transfer. During the access phase, the ready, error and read data of that child are the only ones brought back to the requester.

Write and read responses are gathered on separate paths and then merged onto the single upstream ready/error pair. An address that falls in no window selects no child. The block then completes the transfer on its own in the first access cycle, with the error flag set and the read data at zero, so the requester is never left waiting on a completer that does not exist.

Top module: `apb_range_splitter`

## Requirements
- R1: While `s_psel` is high, `m_psel` has exactly the bit of the child whose window [base, base+size) contains `s_paddr` set, or no bit when no window matches. `m_psel` is zero when `s_psel` is low. At most one bit is ever set, and the lowest index wins if windows overlap.
- R2: `s_penable`, `s_pwrite`, `s_paddr` and `s_pwdata` reach every child unchanged.
- R3: With `USE_STRB` = 1, `s_pstrb` reaches every child unchanged as the write byte enable. With `USE_STRB` = 0, every child sees all strobe bits set.
- R4: A read to a mapped window returns that child's `m_pready`, `m_pslverr` and data slice (bits [k*DATA_W +: DATA_W] for child k) on the upstream port during the access phase. The transfer therefore lasts as many access cycles as the child stalls.
- R5: A write to a mapped window returns that child's ready and error upstream, and `s_prdata` stays zero throughout the write.
- R6: On an address that matches no window, `s_pready` and `s_pslverr` are both high in the first access cycle, `s_prdata` is zero and no child is selected. No child sees a write.
- R7: Outside an access phase (`s_psel` and `s_penable` not both high), `s_pready`, `s_pslverr` and `s_prdata` are all zero, whatever the children drive.
- R8: The target is captured in the setup phase. A change of `s_paddr` during the access phase does not move the select or the response to another child.
- R9: Synchronous active-low reset clears the captured target. After reset, an access phase that is not preceded by a setup phase selects no child and receives no ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_psel | input | 1 | Upstream select |
| s_penable | input | 1 | Upstream enable (access phase) |
| s_pwrite | input | 1 | Upstream direction, 1 = write |
| s_paddr | input | ADDR_W | Upstream address |
| s_pwdata | input | DATA_W | Upstream write data |
| s_pstrb | input | DATA_W/8 | Upstream byte strobes |
| s_pready | output | 1 | Upstream transfer done |
| s_pslverr | output | 1 | Upstream error response |
| s_prdata | output | DATA_W | Upstream read data |
| m_psel | output | NUM_CHILD | One select per child |
| m_penable | output | 1 | Enable broadcast to children |
| m_pwrite | output | 1 | Direction broadcast to children |
| m_paddr | output | ADDR_W | Address broadcast to children |
| m_pwdata | output | DATA_W | Write data broadcast to children |
| m_pstrb | output | DATA_W/8 | Byte enables broadcast to children |
| m_pready | input | NUM_CHILD | Ready from each child |
| m_pslverr | input | NUM_CHILD | Error from each child |
| m_prdata | input | NUM_CHILD*DATA_W | Read data from each child, child k in slice k |

## Verification
The bench builds the block with four children, a 16-bit address, 32-bit data and strobes enabled. The windows have unequal sizes and leave holes between them and at the top of the address space, so both window edges and every kind of hole can be reached. Child k in the bench stalls for k cycles, which covers stalls from zero to three wait states. Each child reports an error on one address pattern, and read data that names the child and the address, so a mis-route shows up in the data.

// File: rtl/apb_split_pkg.sv
// Shared types and helpers for the APB range splitter.
// Assumes addresses no wider than 64 bits.
package apb_split_pkg;

    // Handshake result gathered from one direction of the fan-in.
    typedef struct packed {
        logic ack;
        logic err;
    } apb_status_t;

    // True when addr lies in [base, base+size); 64-bit math avoids wrap at the top.
    function automatic logic range_hit(input logic [63:0] addr,
                                       input logic [63:0] base,
                                       input logic [63:0] size);
        return (addr >= base) && (addr < base + size);
    endfunction

endpackage

// File: rtl/apb_range_decode.sv
// Address window decoder: compares the address against every child window
// and returns a one-hot (or empty) hit vector plus a miss flag.
// Assumes windows do not overlap; if they do, the lowest index wins.
module apb_range_decode
    import apb_split_pkg::*;
#(
    parameter int                          NUM_CHILD  = 4,
    parameter int                          ADDR_W     = 16,
    parameter logic [NUM_CHILD*ADDR_W-1:0] CHILD_BASE = '0,
    parameter logic [NUM_CHILD*ADDR_W-1:0] CHILD_SIZE = '0
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_CHILD-1:0] hit,
    output logic                 miss
);

    logic [NUM_CHILD-1:0] raw_hit;

    // One window comparator per child.
    for (genvar k = 0; k < NUM_CHILD; k++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE_K = CHILD_BASE[k*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] SIZE_K = CHILD_SIZE[k*ADDR_W +: ADDR_W];
        assign raw_hit[k] = range_hit(64'(addr), 64'(BASE_K), 64'(SIZE_K));
    end

    // Keep only the lowest matching index so the output is never multi-hot.
    always_comb begin
        logic taken;
        taken = 1'b0;
        hit   = '0;
        for (int k = 0; k < NUM_CHILD; k++) begin
            if (raw_hit[k] && !taken) begin
                hit[k] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    assign miss = ~|raw_hit;

endmodule

// File: rtl/apb_sel_hold.sv
// Transfer target register: captures the decoded child (or a miss) in the
// setup phase and holds it through the access phase, so the route cannot
// move while a child is stalling. Assumes standard APB phase order.
module apb_sel_hold #(
    parameter int NUM_CHILD = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic [NUM_CHILD-1:0] live_hit,
    input  logic                 live_miss,
    output logic [NUM_CHILD-1:0] child_sel,
    output logic [NUM_CHILD-1:0] route,
    output logic                 miss_active
);

    logic [NUM_CHILD-1:0] held_hit;
    logic                 held_miss;
    logic                 setup_ph;
    logic                 access_ph;

    assign setup_ph  = psel & ~penable;
    assign access_ph = psel & penable;

    // Capture the decode result once per transfer, in its setup phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_hit  <= '0;
            held_miss <= 1'b0;
        end else if (setup_ph) begin
            held_hit  <= live_hit;
            held_miss <= live_miss;
        end
    end

    // Setup phase selects from the live decode, access phase from the held one.
    always_comb begin
        if (!psel)        child_sel = '0;
        else if (penable) child_sel = held_hit;
        else              child_sel = live_hit;
    end

    // Fan-in routing and the miss responder are only live in the access phase.
    assign route       = access_ph ? held_hit : '0;
    assign miss_active = access_ph & held_miss;

endmodule

// File: rtl/apb_resp_gather.sv
// Response fan-in: gathers ready/error/data from the routed child on
// separate write and read paths, adds the self-response for unmapped
// addresses, and merges both paths onto one upstream response.
// Assumes route is at most one-hot.
module apb_resp_gather
    import apb_split_pkg::*;
#(
    parameter int NUM_CHILD = 4,
    parameter int DATA_W    = 32
) (
    input  logic                        pwrite,
    input  logic [NUM_CHILD-1:0]        route,
    input  logic                        miss_active,
    input  logic [NUM_CHILD-1:0]        child_ready,
    input  logic [NUM_CHILD-1:0]        child_err,
    input  logic [NUM_CHILD*DATA_W-1:0] child_rdata,
    output logic                        pready,
    output logic                        pslverr,
    output logic [DATA_W-1:0]           prdata
);

    logic [NUM_CHILD-1:0] wr_route;
    logic [NUM_CHILD-1:0] rd_route;
    apb_status_t          wr_st;
    apb_status_t          rd_st;
    logic [DATA_W-1:0]    rd_data;

    assign wr_route = route & {NUM_CHILD{pwrite}};
    assign rd_route = route & {NUM_CHILD{~pwrite}};

    // Write path: response of the write-routed child, or the miss response.
    always_comb begin
        wr_st = '0;
        for (int k = 0; k < NUM_CHILD; k++) begin
            if (wr_route[k]) wr_st = '{ack: child_ready[k], err: child_err[k]};
        end
        if (miss_active && pwrite) wr_st = '{ack: 1'b1, err: 1'b1};
    end

    // Read path: response and data of the read-routed child, or the miss response.
    always_comb begin
        rd_st   = '0;
        rd_data = '0;
        for (int k = 0; k < NUM_CHILD; k++) begin
            if (rd_route[k]) begin
                rd_st   = '{ack: child_ready[k], err: child_err[k]};
                rd_data = child_rdata[k*DATA_W +: DATA_W];
            end
        end
        if (miss_active && !pwrite) begin
            rd_st   = '{ack: 1'b1, err: 1'b1};
            rd_data = '0;
        end
    end

    assign pready  = wr_st.ack | rd_st.ack;
    assign pslverr = wr_st.err | rd_st.err;
    assign prdata  = rd_data;

endmodule

// File: rtl/apb_range_splitter.sv
// APB range splitter top: one upstream requester to NUM_CHILD completers,
// each owning the window [base, base+size) from the parameter tables.
// Unmapped addresses are completed locally with an error in one access cycle.
// Assumes non-overlapping windows and a protocol-compliant requester.
module apb_range_splitter #(
    parameter int                          NUM_CHILD  = 4,
    parameter int                          ADDR_W     = 16,
    parameter int                          DATA_W     = 32,
    parameter bit                          USE_STRB   = 1'b1,
    parameter logic [NUM_CHILD*ADDR_W-1:0] CHILD_BASE = {16'h4000, 16'h2000, 16'h1000, 16'h0000},
    parameter logic [NUM_CHILD*ADDR_W-1:0] CHILD_SIZE = {16'h2000, 16'h1000, 16'h0800, 16'h1000},
    localparam int                         STRB_W     = DATA_W / 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        s_psel,
    input  logic                        s_penable,
    input  logic                        s_pwrite,
    input  logic [ADDR_W-1:0]           s_paddr,
    input  logic [DATA_W-1:0]           s_pwdata,
    input  logic [STRB_W-1:0]           s_pstrb,
    output logic                        s_pready,
    output logic                        s_pslverr,
    output logic [DATA_W-1:0]           s_prdata,
    output logic [NUM_CHILD-1:0]        m_psel,
    output logic                        m_penable,
    output logic                        m_pwrite,
    output logic [ADDR_W-1:0]           m_paddr,
    output logic [DATA_W-1:0]           m_pwdata,
    output logic [STRB_W-1:0]           m_pstrb,
    input  logic [NUM_CHILD-1:0]        m_pready,
    input  logic [NUM_CHILD-1:0]        m_pslverr,
    input  logic [NUM_CHILD*DATA_W-1:0] m_prdata
);

    logic [NUM_CHILD-1:0] live_hit;
    logic                 live_miss;
    logic [NUM_CHILD-1:0] route;
    logic                 miss_active;

    apb_range_decode #(
        .NUM_CHILD (NUM_CHILD),
        .ADDR_W    (ADDR_W),
        .CHILD_BASE(CHILD_BASE),
        .CHILD_SIZE(CHILD_SIZE)
    ) u_decode (
        .addr(s_paddr),
        .hit (live_hit),
        .miss(live_miss)
    );

    apb_sel_hold #(
        .NUM_CHILD(NUM_CHILD)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (s_psel),
        .penable    (s_penable),
        .live_hit   (live_hit),
        .live_miss  (live_miss),
        .child_sel  (m_psel),
        .route      (route),
        .miss_active(miss_active)
    );

    apb_resp_gather #(
        .NUM_CHILD(NUM_CHILD),
        .DATA_W   (DATA_W)
    ) u_gather (
        .pwrite     (s_pwrite),
        .route      (route),
        .miss_active(miss_active),
        .child_ready(m_pready),
        .child_err  (m_pslverr),
        .child_rdata(m_prdata),
        .pready     (s_pready),
        .pslverr    (s_pslverr),
        .prdata     (s_prdata)
    );

    // Broadcast of the transfer fields to every child.
    assign m_penable = s_penable;
    assign m_pwrite  = s_pwrite;
    assign m_paddr   = s_paddr;
    assign m_pwdata  = s_pwdata;

    // Byte enables: forwarded when strobes exist, otherwise full-word writes.
    if (USE_STRB) begin : g_strb_fwd
        assign m_pstrb = s_pstrb;
    end else begin : g_strb_full
        assign m_pstrb = '1;
    end

endmodule

// File: rtl/apb_range_splitter_chk.sv
// Protocol checker for the APB range splitter, attached by bind below.
module apb_range_splitter_chk #(
    parameter int NUM_CHILD = 4,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 s_psel,
    input logic                 s_penable,
    input logic                 s_pwrite,
    input logic                 s_pready,
    input logic                 s_pslverr,
    input logic [DATA_W-1:0]    s_prdata,
    input logic [NUM_CHILD-1:0] m_psel
);

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_psel));

    assert_wr_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_psel && s_penable && s_pwrite) |-> (s_prdata == '0));

    assert_miss_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_psel && s_penable && (m_psel == '0) && $past(s_psel && !s_penable))
        |-> (s_pready && s_pslverr));

    assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_psel && s_penable) |-> (!s_pready && !s_pslverr && (s_prdata == '0)));

    assert_sel_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_psel && s_penable && $past(s_psel)) |-> $stable(m_psel));

endmodule

bind apb_range_splitter apb_range_splitter_chk #(
    .NUM_CHILD(NUM_CHILD),
    .DATA_W   (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_psel   (s_psel),
    .s_penable(s_penable),
    .s_pwrite (s_pwrite),
    .s_pready (s_pready),
    .s_pslverr(s_pslverr),
    .s_prdata (s_prdata),
    .m_psel   (m_psel)
);

// File: tb/apb_range_splitter_test.sv
`timescale 1ns/1ps
// Bench: four child models (child k stalls k cycles, errors on low byte 0xEC,
// read data = {k, 0xA5, addr}), random plus directed transfers.
module apb_range_splitter_test;

    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            s_psel = 1'b0, s_penable = 1'b0, s_pwrite = 1'b0;
    logic [AW-1:0]   s_paddr = '0;
    logic [DW-1:0]   s_pwdata = '0;
    logic [SW-1:0]   s_pstrb = '0;
    logic            s_pready, s_pslverr;
    logic [DW-1:0]   s_prdata;
    logic [N-1:0]    m_psel;
    logic            m_penable, m_pwrite;
    logic [AW-1:0]   m_paddr;
    logic [DW-1:0]   m_pwdata;
    logic [SW-1:0]   m_pstrb;
    logic [N-1:0]    c_ready, c_err;
    logic [N*DW-1:0] c_rdata;

    int              total = 0;
    int              bad   = 0;
    bit              done  = 1'b0;

    always #10 clk = ~clk;

    apb_range_splitter #(
        .NUM_CHILD (N), .ADDR_W(AW), .DATA_W(DW), .USE_STRB(1'b1),
        .CHILD_BASE({16'h4000, 16'h2000, 16'h1000, 16'h0000}),
        .CHILD_SIZE({16'h2000, 16'h1000, 16'h0800, 16'h1000})
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .s_psel(s_psel), .s_penable(s_penable), .s_pwrite(s_pwrite),
        .s_paddr(s_paddr), .s_pwdata(s_pwdata), .s_pstrb(s_pstrb),
        .s_pready(s_pready), .s_pslverr(s_pslverr), .s_prdata(s_prdata),
        .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite),
        .m_paddr(m_paddr), .m_pwdata(m_pwdata), .m_pstrb(m_pstrb),
        .m_pready(c_ready), .m_pslverr(c_err), .m_prdata(c_rdata)
    );

    // Child models: wait counters and last-write capture.
    int          wait_cnt [N];
    int          wcnt     [N];
    logic [15:0] last_wa  [N];
    logic [31:0] last_wd  [N];
    logic [3:0]  last_ws  [N];

    always_ff @(posedge clk) begin
        for (int k = 0; k < N; k++) begin
            if (!rst_n) begin
                wait_cnt[k] <= 0;
                wcnt[k]     <= 0;
                last_wa[k]  <= '0;
                last_wd[k]  <= '0;
                last_ws[k]  <= '0;
            end else if (m_psel[k] && m_penable) begin
                if (wait_cnt[k] == k) begin
                    wait_cnt[k] <= 0;
                    if (m_pwrite) begin
                        wcnt[k]    <= wcnt[k] + 1;
                        last_wa[k] <= m_paddr;
                        last_wd[k] <= m_pwdata;
                        last_ws[k] <= m_pstrb;
                    end
                end else begin
                    wait_cnt[k] <= wait_cnt[k] + 1;
                end
            end else begin
                wait_cnt[k] <= 0;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < N; k++) begin
            c_ready[k]            = m_psel[k] && m_penable && (wait_cnt[k] == k);
            c_err[k]              = c_ready[k] && (m_paddr[7:0] == 8'hEC);
            c_rdata[k*DW +: DW]   = {8'(k), 8'hA5, m_paddr};
        end
    end

    function automatic int exp_idx(input logic [15:0] a);
        if (a < 16'h1000)                     return 0;
        if (a >= 16'h1000 && a < 16'h1800)    return 1;
        if (a >= 16'h2000 && a < 16'h3000)    return 2;
        if (a >= 16'h4000 && a < 16'h6000)    return 3;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [15:0] a, input logic [31:0] d,
                        input logic [3:0] s, output logic [31:0] rd, output bit er,
                        output int cyc, output logic [3:0] sel_seen);
        @(negedge clk);
        s_psel = 1'b1; s_penable = 1'b0; s_pwrite = wr;
        s_paddr = a; s_pwdata = d; s_pstrb = s;
        #1 sel_seen = m_psel;
        @(negedge clk);
        s_penable = 1'b1;
        cyc = 1;
        #1;
        while (!s_pready && cyc < 50) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        rd = s_prdata;
        er = s_pslverr;
        @(negedge clk);
        s_psel = 1'b0; s_penable = 1'b0;
        #1;
        check(!s_pready && !s_pslverr && s_prdata == '0, "R7", "idle response",
              {s_pready, s_pslverr, s_prdata[29:0]}, 32'h0);
    endtask

    task automatic run_one(input bit wr, input logic [15:0] a);
        int          idx;
        int          old [N];
        logic [31:0] d, rd;
        logic [3:0]  s, sel;
        bit          er;
        int          cyc;
        idx = exp_idx(a);
        for (int k = 0; k < N; k++) old[k] = wcnt[k];
        d = $urandom;
        s = 4'($urandom);
        xfer(wr, a, d, s, rd, er, cyc, sel);
        check(sel == ((idx < 0) ? 4'h0 : 4'(1 << idx)), "R1", "setup select", 32'(sel),
              (idx < 0) ? 32'h0 : 32'(1 << idx));
        if (idx < 0) begin
            check(cyc == 1, "R6", "miss cycles", 32'(cyc), 32'd1);
            check(er, "R6", "miss error", 32'(er), 32'd1);
            check(rd == 32'h0, "R6", "miss data", rd, 32'h0);
            for (int k = 0; k < N; k++)
                check(wcnt[k] == old[k], "R6", "no child write", 32'(wcnt[k]), 32'(old[k]));
        end else begin
            check(cyc == idx + 1, wr ? "R5" : "R4", "access cycles", 32'(cyc), 32'(idx + 1));
            check(er == (a[7:0] == 8'hEC), wr ? "R5" : "R4", "error", 32'(er),
                  32'(a[7:0] == 8'hEC));
            if (wr) begin
                check(rd == 32'h0, "R5", "write data zero", rd, 32'h0);
                check(wcnt[idx] == old[idx] + 1, "R5", "child write count",
                      32'(wcnt[idx]), 32'(old[idx] + 1));
                check(last_wa[idx] == a && last_wd[idx] == d, "R2", "broadcast data",
                      last_wd[idx], d);
                check(last_ws[idx] == s, "R3", "strobes", 32'(last_ws[idx]), 32'(s));
            end else begin
                check(rd == {8'(idx), 8'hA5, a}, "R4", "read data", rd, {8'(idx), 8'hA5, a});
            end
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(20ns * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20260));
        repeat (3) @(negedge clk);
        #1;
        check(!s_pready && !s_pslverr && s_prdata == '0 && m_psel == '0, "R9",
              "reset outputs", {s_pready, s_pslverr, 26'h0, m_psel}, 32'h0);
        // R9: access phase with no setup right after reset gets no answer.
        @(negedge clk);
        rst_n = 1'b1;
        s_psel = 1'b1; s_penable = 1'b1; s_pwrite = 1'b0; s_paddr = 16'h0010;
        #1;
        check(m_psel == '0 && !s_pready, "R9", "no setup access",
              {31'h0, s_pready} | 32'(m_psel), 32'h0);
        @(negedge clk);
        #1;
        check(m_psel == '0 && !s_pready, "R9", "no setup access held",
              {31'h0, s_pready} | 32'(m_psel), 32'h0);
        s_psel = 1'b0; s_penable = 1'b0;

        // Directed: read and write each child, window edges, holes.
        run_one(1'b0, 16'h0000); run_one(1'b1, 16'h0FFF);
        run_one(1'b0, 16'h1000); run_one(1'b1, 16'h17FF);
        run_one(1'b0, 16'h2FFF); run_one(1'b1, 16'h2000);
        run_one(1'b0, 16'h5FFF); run_one(1'b1, 16'h4000);
        run_one(1'b0, 16'h1800); run_one(1'b1, 16'h1FFF);
        run_one(1'b0, 16'h3000); run_one(1'b1, 16'h3FFF);
        run_one(1'b0, 16'h6000); run_one(1'b1, 16'hFFFF);
        run_one(1'b0, 16'h10EC); run_one(1'b1, 16'h40EC);
        run_one(1'b0, 16'h00EC); run_one(1'b1, 16'h20EC);

        // R8: address moved during the access phase must not reroute.
        begin
            @(negedge clk);
            s_psel = 1'b1; s_penable = 1'b0; s_pwrite = 1'b0; s_paddr = 16'h0040;
            @(negedge clk);
            s_penable = 1'b1; s_paddr = 16'h2040;
            #1;
            check(m_psel == 4'b0001, "R8", "frozen select", 32'(m_psel), 32'h1);
            check(s_pready && s_prdata == {8'h00, 8'hA5, 16'h2040}, "R8", "frozen response",
                  s_prdata, {8'h00, 8'hA5, 16'h2040});
            @(negedge clk);
            s_psel = 1'b0; s_penable = 1'b0;
        end

        // Random transfers over the whole space, some on the error pattern.
        for (int i = 0; i < 150; i++) begin
            logic [15:0] a;
            a = 16'($urandom_range(0, 16'h7FFF));
            if ($urandom_range(0, 7) == 0) a[7:0] = 8'hEC;
            if ($urandom_range(0, 15) == 0) a[15] = 1'b1;
            run_one(1'($urandom), a);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule